// File: doc/BRIEF.md
# High Address Translation Unit

This block sits between the high-order address lines of whichever processor is currently active and the translated high address lines that feed memory and the expansion interface. While the processor owns the bus, the block can move page zero and page one to any other page. When the secondary processor is active, the block also steers that processor's accesses in the lowest 4 KB towards the boot ROM image. While the bus belongs to the video controller or a DMA master, the block stops translating. It forces the upper lines high and releases the lower lines so that the other master can drive them.

Two 8-bit relocation registers hold the target pages for page zero and page one. They are loaded through a simple write strobe. Translation is purely combinational from the page number, the register contents, the processor-select input and the bus-owner input. The translated value of address bit 12 is brought out on a separate pin, where it serves as a ROM address line for relocating the secondary processor's ROM.

Top module: `hi_addr_xlat`

## Requirements
- R1: After reset the page-zero target register holds 0x00 and the page-one target register holds 0x01, so every page maps to itself in primary mode.
- R2: With `cfg_we`=1 at a rising clock edge, `cfg_sel`=0 loads `cfg_data` into the page-zero target and `cfg_sel`=1 loads it into the page-one target. Translations use the new value from that edge onward.
- R3: With `bus_own`=1 and the boot redirection not applying, page 0x00 translates to the page-zero target, and page 0x01 translates to the page-one target.
- R4: With `bus_own`=1 and no earlier rule applying, a page equal to the page-zero target translates to 0x00. Otherwise, a page equal to the page-one target translates to 0x01. The page-zero comparison wins when both targets are equal.
- R5: With `bus_own`=1, `sec_mode`=1 and a page from 0x00 to 0x0F, the output is the page with bit 4 (TA12) set. This rule takes priority over all relocation.
- R6: With `bus_own`=1 and no rule from R3 to R5 applying, the page passes through unchanged.
- R7: With `bus_own`=0, `ta_hi[7:4]` is 4'b1111, `ta_hi[3:0]` is 4'b0000 and `ta_lo_oe` is 0, whatever the page, mode and register contents.
- R8: With `bus_own`=1, `ta_lo_oe` is 1.
- R9: `rom_a12` always equals `ta_hi[4]`.
- R10: A register write made while `bus_own`=0 still takes effect and is used by later processor-owned translations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the relocation registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for a relocation register |
| cfg_sel | input | 1 | 0 selects the page-zero target, 1 selects the page-one target |
| cfg_data | input | 8 | Target page to be written |
| bus_own | input | 1 | 1 when the processor owns the bus, 0 in video or DMA cycles |
| sec_mode | input | 1 | 1 when the secondary processor is active |
| a_hi | input | 8 | High address lines A8 to A15 from the active processor |
| ta_hi | output | 8 | Translated high address lines TA8 to TA15 |
| ta_lo_oe | output | 1 | Drive enable for TA8 to TA11 (0 means released) |
| rom_a12 | output | 1 | Translated bit 12 for the ROM address line |

## Verification
The bench builds the block with its default parameters: 8 high lines, the upper 4 forced during foreign cycles, a 16-page boot window and TA12 as the redirect bit. With a page number only 8 bits wide, every page can be swept exhaustively under each combination of mode and bus ownership. This is done for the identity mapping and again after relocation. Chosen register contents then reach the corner cases: equal targets, a page-zero target of 0x01, targets inside the boot window, and writes made during foreign cycles.

// File: rtl/hax_pkg.sv
package hax_pkg;

    // Which rule produced the translated page
    typedef enum logic [2:0] {
        RT_PASS  = 3'd0,
        RT_BOOT  = 3'd1,
        RT_ZERO  = 3'd2,
        RT_ONE   = 3'd3,
        RT_BACK0 = 3'd4,
        RT_BACK1 = 3'd5
    } route_e;

endpackage

// File: rtl/hax_reloc_regs.sv
module hax_reloc_regs #(
    parameter int HI_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic            cfg_sel,
    input  logic [HI_W-1:0] cfg_data,
    output logic [HI_W-1:0] zero_tgt,
    output logic [HI_W-1:0] one_tgt
);
    localparam logic [HI_W-1:0] ZERO_RST = '0;
    localparam logic [HI_W-1:0] ONE_RST  = HI_W'(1);

    typedef struct packed {
        logic [HI_W-1:0] zero;
        logic [HI_W-1:0] one;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (cfg_we) begin
            if (cfg_sel) regs_d.one  = cfg_data;
            else         regs_d.zero = cfg_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.zero <= ZERO_RST;
            regs_q.one  <= ONE_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign zero_tgt = regs_q.zero;
    assign one_tgt  = regs_q.one;

    // R2
    zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_sel) |=> (zero_tgt == $past(cfg_data)));

    // R2
    one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel) |=> (one_tgt == $past(cfg_data)));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(zero_tgt) && $stable(one_tgt)));

endmodule

// File: rtl/hax_page_map.sv
module hax_page_map
    import hax_pkg::*;
#(
    parameter int HI_W      = 8,
    parameter int BOOT_SPAN = 16,
    parameter int BOOT_BIT  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_own,
    input  logic            sec_mode,
    input  logic [HI_W-1:0] page,
    input  logic [HI_W-1:0] zero_tgt,
    input  logic [HI_W-1:0] one_tgt,
    output logic [HI_W-1:0] mapped,
    output route_e          route
);
    localparam logic [HI_W-1:0] PAGE_ZERO = '0;
    localparam logic [HI_W-1:0] PAGE_ONE  = HI_W'(1);
    localparam logic [HI_W-1:0] BOOT_MASK = HI_W'(1) << BOOT_BIT;
    localparam logic [HI_W-1:0] BOOT_TOP  = HI_W'(BOOT_SPAN);

    typedef struct packed {
        logic [HI_W-1:0] page;
        route_e          route;
    } map_t;

    map_t map_d;

    always_comb begin
        map_d.page  = page;
        map_d.route = RT_PASS;
        if (sec_mode && (page < BOOT_TOP)) begin
            map_d.page  = page | BOOT_MASK;
            map_d.route = RT_BOOT;
        end else if (page == PAGE_ZERO) begin
            map_d.page  = zero_tgt;
            map_d.route = RT_ZERO;
        end else if (page == PAGE_ONE) begin
            map_d.page  = one_tgt;
            map_d.route = RT_ONE;
        end else if (page == zero_tgt) begin
            map_d.page  = PAGE_ZERO;
            map_d.route = RT_BACK0;
        end else if (page == one_tgt) begin
            map_d.page  = PAGE_ONE;
            map_d.route = RT_BACK1;
        end
    end

    assign mapped = map_d.page;
    assign route  = map_d.route;

    // R5
    boot_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_mode && (page < BOOT_TOP)) |-> (mapped[BOOT_BIT] && route == RT_BOOT));

    // R4
    back_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_own && route == RT_BACK0) |-> (mapped == PAGE_ZERO && page == zero_tgt));

    // R6
    pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route == RT_PASS) |-> (mapped == page));

endmodule

// File: rtl/hax_bus_yield.sv
module hax_bus_yield #(
    parameter int HI_W    = 8,
    parameter int FORCE_W = 4
) (
    input  logic            bus_own,
    input  logic [HI_W-1:0] mapped,
    output logic [HI_W-1:0] ta,
    output logic            lo_oe
);
    localparam int LO_W = HI_W - FORCE_W;

    always_comb begin
        if (bus_own) begin
            ta    = mapped;
            lo_oe = 1'b1;
        end else begin
            ta    = {{FORCE_W{1'b1}}, {LO_W{1'b0}}};
            lo_oe = 1'b0;
        end
    end

endmodule

// File: rtl/hi_addr_xlat.sv
module hi_addr_xlat
    import hax_pkg::*;
#(
    parameter int HI_W      = 8,
    parameter int FORCE_W   = 4,
    parameter int BOOT_SPAN = 16,
    parameter int BOOT_BIT  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic            cfg_sel,
    input  logic [HI_W-1:0] cfg_data,
    input  logic            bus_own,
    input  logic            sec_mode,
    input  logic [HI_W-1:0] a_hi,
    output logic [HI_W-1:0] ta_hi,
    output logic            ta_lo_oe,
    output logic            rom_a12
);
    localparam int LO_W = HI_W - FORCE_W;

    logic [HI_W-1:0] zero_tgt, one_tgt, mapped;
    route_e          route;

    hax_reloc_regs #(.HI_W(HI_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_data (cfg_data),
        .zero_tgt (zero_tgt),
        .one_tgt  (one_tgt)
    );

    hax_page_map #(
        .HI_W      (HI_W),
        .BOOT_SPAN (BOOT_SPAN),
        .BOOT_BIT  (BOOT_BIT)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_own  (bus_own),
        .sec_mode (sec_mode),
        .page     (a_hi),
        .zero_tgt (zero_tgt),
        .one_tgt  (one_tgt),
        .mapped   (mapped),
        .route    (route)
    );

    hax_bus_yield #(.HI_W(HI_W), .FORCE_W(FORCE_W)) u_yield (
        .bus_own (bus_own),
        .mapped  (mapped),
        .ta      (ta_hi),
        .lo_oe   (ta_lo_oe)
    );

    assign rom_a12 = ta_hi[BOOT_BIT];

    // R7
    yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_own |-> (ta_hi[HI_W-1:LO_W] == {FORCE_W{1'b1}} && !ta_lo_oe));

    // R8
    own_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_own |-> ta_lo_oe);

    // R3
    zero_reloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_own && !sec_mode && a_hi == '0) |-> (ta_hi == zero_tgt));

endmodule

// File: tb/hi_addr_xlat_test.sv
module hi_addr_xlat_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [7:0] cfg_data = '0;
    logic       bus_own = 1'b1, sec_mode = 1'b0;
    logic [7:0] a_hi = '0;
    logic [7:0] ta_hi;
    logic       ta_lo_oe, rom_a12;

    int n_cmp = 0, n_bad = 0;
    int m_zero = 0, m_one = 1;

    always #4 clk = ~clk;

    hi_addr_xlat uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .bus_own(bus_own), .sec_mode(sec_mode),
        .a_hi(a_hi), .ta_hi(ta_hi), .ta_lo_oe(ta_lo_oe), .rom_a12(rom_a12)
    );

    function automatic int model_ta(int pg, bit own, bit sec);
        if (!own) return 'hF0;
        if (sec && pg < 16) return pg | 16;
        if (pg == 0) return m_zero;
        if (pg == 1) return m_one;
        if (pg == m_zero) return 0;
        if (pg == m_one) return 1;
        return pg;
    endfunction

    // One cycle: drive at falling edge, compare mid-low-phase, commit writes at rising edge
    task automatic cyc(string req, int pg, bit own, bit sec,
                       bit we = 0, bit sel = 0, int data = 0);
        int exp_ta;
        @(negedge clk);
        a_hi = 8'(pg); bus_own = own; sec_mode = sec;
        cfg_we = we; cfg_sel = sel; cfg_data = 8'(data);
        #2;
        exp_ta = model_ta(pg, own, sec);
        n_cmp++;
        if (ta_hi !== 8'(exp_ta) || ta_lo_oe !== own || rom_a12 !== exp_ta[4]) begin
            n_bad++;
            $display("FAIL %s: page %02h own %0b sec %0b ta %02h oe %0b a12 %0b, expected ta %02h oe %0b a12 %0b",
                     req, pg, own, sec, ta_hi, ta_lo_oe, rom_a12, exp_ta, own, exp_ta[4]);
        end
        @(posedge clk);
        if (we) begin
            if (sel) m_one = data; else m_zero = data;
        end
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 identity after reset, R6 R9 across all pages
        for (int p = 0; p < 256; p++) cyc("R1", p, 1, 0);
        // R7 foreign cycles, all modes
        for (int p = 0; p < 256; p += 7) cyc("R7", p, 0, p[0]);
        // R5 boot window, identity targets
        for (int p = 0; p < 32; p++) cyc("R5", p, 1, 1);
        // R2 load targets
        cyc("R2", 0, 1, 0, 1, 0, 'h40);
        cyc("R2", 0, 1, 0, 1, 1, 'h80);
        // R3 R4 R6 full sweep after relocation
        for (int p = 0; p < 256; p++) cyc("R4", p, 1, 0);
        // R5 priority over relocation; targets 0x40/0x80 outside window
        for (int p = 0; p < 256; p++) cyc("R5", p, 1, 1);
        // R4 equal targets: page-zero comparison wins
        cyc("R2", 3, 1, 0, 1, 0, 'h22);
        cyc("R2", 3, 1, 0, 1, 1, 'h22);
        cyc("R4", 'h22, 1, 0);
        cyc("R3", 0, 1, 0);
        cyc("R3", 1, 1, 0);
        // R4 page-zero target equals page one
        cyc("R2", 5, 1, 0, 1, 0, 'h01);
        for (int p = 0; p < 4; p++) cyc("R4", p, 1, 0);
        cyc("R4", 'h22, 1, 0);
        // R5 targets inside the boot window while secondary active
        cyc("R2", 5, 1, 0, 1, 0, 'h05);
        cyc("R2", 5, 1, 0, 1, 1, 'h0C);
        for (int p = 0; p < 20; p++) cyc("R5", p, 1, 1);
        for (int p = 0; p < 20; p++) cyc("R4", p, 1, 0);
        // R10 writes during foreign cycles
        cyc("R10", 9, 0, 0, 1, 0, 'hA5);
        cyc("R10", 9, 0, 1, 1, 1, 'h5A);
        cyc("R10", 0, 1, 0);
        cyc("R10", 1, 1, 0);
        cyc("R10", 'hA5, 1, 0);
        cyc("R10", 'h5A, 1, 0);
        cyc("R7", 'hA5, 0, 0);
        // R8 drive enable returns with ownership
        cyc("R8", 'h33, 1, 0);
        // R1 reset restores identity
        @(negedge clk); rst_n = 1'b0; m_zero = 0; m_one = 1;
        @(negedge clk); rst_n = 1'b1;
        for (int p = 0; p < 256; p += 5) cyc("R1", p, 1, 0);
        cyc("R1", 1, 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule